// File: doc/BRIEF.md
# Host Mailbox Interrupt Controller

This block sits between an external host and an embedded processor core and gives them six shared 16-bit mailbox words. Each word has its own host write strobe and host read strobe. The core reaches the words through a small memory-mapped window. That window also holds a read-only pending-status word and a read/write enable mask.

Every mailbox word carries two sticky flags. One records that the host deposited data. The other records that the host consumed data. Only the core's matching data access removes a flag. A core read of word n retires its host-write flag. A core write of word n retires its host-read flag.

The enabled flags in each direction are ORed into two registered interrupt requests. Each request comes with a fixed vector address. Neither servicing an interrupt nor any software access to the control words can raise or drop a flag.

Top module: `hmb_ctrl`

## Requirements
- R1: After reset all pending flags are zero, the mask reads 0x0000, the status word reads 0x0000 and both interrupt requests are low.
- R2: A host write strobe on word n sets host-write flag n. A host read strobe on word n sets host-read flag n. Both changes are visible in the status word after the clock edge that samples the strobe.
- R3: A core read of word n (address 0x3FE0+n) clears only host-write flag n. A core write of word n clears only host-read flag n. No other flag changes.
- R4: If a flag is set and cleared in the same cycle, the set wins. This covers a host write together with a core read of the same word, and a host read together with a core write of the same word.
- R5: The mask sits at core address 0x3FE8. Bits 0-5 enable the host-write flags of words 0-5 and bits 8-13 enable the host-read flags of words 0-5. Bits 6, 7, 14 and 15 read zero and ignore writes. 1 enables.
- R6: irq_hwr_o goes high one clock after any host-write flag and its mask bit are both 1, and irq_hrd_o does the same for the host-read flags. Each request falls one clock after the last enabled flag of its direction is cleared.
- R7: Core writes to the status address, and core reads of the status or mask address, never set or clear a pending flag.
- R8: vec_hwr_o is constantly 0x0008 and vec_hrd_o is constantly 0x000C.
- R9: Data written by either side is read back by the other: by the core at 0x3FE0+n, by the host on host_rdata_o while host_rd_i[n] is high. When the host and the core write the same word in the same cycle, the host value is stored.
- R10: The status word at core address 0x3FE6 is read-only. Bits 0-5 hold the raw host-write flags and bits 8-13 hold the raw host-read flags, before masking. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 6 | Host write strobes, one per mailbox word |
| host_rd_i | input | 6 | Host read strobes, one per mailbox word (one-hot) |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Word selected by host_rd_i |
| core_addr_i | input | 14 | Core word address |
| core_wr_i | input | 1 | Core write enable |
| core_rd_i | input | 1 | Core read enable |
| core_wdata_i | input | 16 | Core write data |
| core_rdata_o | output | 16 | Core read data for core_addr_i |
| irq_hwr_o | output | 1 | Host-write interrupt request |
| irq_hrd_o | output | 1 | Host-read interrupt request |
| vec_hwr_o | output | 14 | Host-write interrupt vector |
| vec_hrd_o | output | 14 | Host-read interrupt vector |

## Verification
The hardest case to reach is a set and a clear of the same flag landing on one clock edge. To reach it, a host strobe and the opposite core access to the same word must be driven in the same cycle. The bench has a task that drives a host strobe and a core access together. It uses that task to collide a host write with a core read, and a host read with a core write. Each collision is followed by a status read, which shows whether the set survived.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_MASK = 2'd3
  } hmb_sel_e;
endpackage

// File: rtl/hmb_decode.sv
module hmb_decode
  import hmb_pkg::*;
#(
  parameter int unsigned N_REG = 6,
  parameter int unsigned AW = 14,
  parameter logic [AW-1:0] DATA_BASE = 14'h3FE0,
  parameter logic [AW-1:0] STAT_ADDR = 14'h3FE6,
  parameter logic [AW-1:0] MASK_ADDR = 14'h3FE8
) (
  input  logic [AW-1:0]    addr_i,
  output hmb_sel_e         sel_o,
  output logic [N_REG-1:0] data_hit_o
);
  for (genvar n = 0; n < N_REG; n++) begin : g_hit
    localparam logic [AW-1:0] WordAddr = DATA_BASE + AW'(n);
    assign data_hit_o[n] = (addr_i == WordAddr);
  end

  always_comb begin
    if (|data_hit_o)              sel_o = SEL_DATA;
    else if (addr_i == STAT_ADDR) sel_o = SEL_STAT;
    else if (addr_i == MASK_ADDR) sel_o = SEL_MASK;
    else                          sel_o = SEL_NONE;
  end
endmodule

// File: rtl/hmb_regfile.sv
module hmb_regfile #(
  parameter int unsigned N_REG = 6,
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REG-1:0] host_we_i,
  input  logic [DW-1:0]    host_wdata_i,
  input  logic [N_REG-1:0] host_re_i,
  output logic [DW-1:0]    host_rdata_o,
  input  logic [N_REG-1:0] core_we_i,
  input  logic [N_REG-1:0] core_sel_i,
  input  logic [DW-1:0]    core_wdata_i,
  output logic [DW-1:0]    core_rdata_o
);
  logic [DW-1:0] word_q [N_REG];

  for (genvar n = 0; n < N_REG; n++) begin : g_word
    logic [DW-1:0] q;
    // host side has priority on a same-cycle write collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           q <= '0;
      else if (host_we_i[n]) q <= host_wdata_i;
      else if (core_we_i[n]) q <= core_wdata_i;
    end
    assign word_q[n] = q;
  end

  always_comb begin
    host_rdata_o = '0;
    core_rdata_o = '0;
    for (int n = 0; n < N_REG; n++) begin
      host_rdata_o |= {DW{host_re_i[n]}} & word_q[n];
      core_rdata_o |= {DW{core_sel_i[n]}} & word_q[n];
    end
  end
endmodule

// File: rtl/hmb_pending.sv
module hmb_pending #(
  parameter int unsigned N_REG = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REG-1:0] set_i,
  input  logic [N_REG-1:0] clr_i,
  output logic [N_REG-1:0] pend_o
);
  for (genvar n = 0; n < N_REG; n++) begin : g_flag
    logic f_q;
    // set beats clear so no host event is lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[n]) f_q <= 1'b1;
      else if (clr_i[n]) f_q <= 1'b0;
    end
    assign pend_o[n] = f_q;
  end
endmodule

// File: rtl/hmb_irq.sv
module hmb_irq #(
  parameter int unsigned N_REG = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [N_REG-1:0] mask_wr_d_i,
  input  logic [N_REG-1:0] mask_rd_d_i,
  input  logic [N_REG-1:0] wr_pend_i,
  input  logic [N_REG-1:0] rd_pend_i,
  output logic [N_REG-1:0] mask_wr_o,
  output logic [N_REG-1:0] mask_rd_o,
  output logic             irq_hwr_o,
  output logic             irq_hrd_o
);
  logic [N_REG-1:0] mask_wr_q, mask_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_wr_q <= '0;
      mask_rd_q <= '0;
    end else if (mask_we_i) begin
      mask_wr_q <= mask_wr_d_i;
      mask_rd_q <= mask_rd_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_hwr_o <= 1'b0;
      irq_hrd_o <= 1'b0;
    end else begin
      irq_hwr_o <= |(wr_pend_i & mask_wr_q);
      irq_hrd_o <= |(rd_pend_i & mask_rd_q);
    end
  end

  assign mask_wr_o = mask_wr_q;
  assign mask_rd_o = mask_rd_q;
endmodule

// File: rtl/hmb_ctrl.sv
module hmb_ctrl
  import hmb_pkg::*;
#(
  parameter int unsigned N_REG = 6,
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 14,
  parameter logic [AW-1:0] DATA_BASE = 14'h3FE0,
  parameter logic [AW-1:0] STAT_ADDR = 14'h3FE6,
  parameter logic [AW-1:0] MASK_ADDR = 14'h3FE8,
  parameter logic [AW-1:0] HWR_VEC = 14'h0008,
  parameter logic [AW-1:0] HRD_VEC = 14'h000C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REG-1:0] host_wr_i,
  input  logic [N_REG-1:0] host_rd_i,
  input  logic [DW-1:0]    host_wdata_i,
  output logic [DW-1:0]    host_rdata_o,
  input  logic [AW-1:0]    core_addr_i,
  input  logic             core_wr_i,
  input  logic             core_rd_i,
  input  logic [DW-1:0]    core_wdata_i,
  output logic [DW-1:0]    core_rdata_o,
  output logic             irq_hwr_o,
  output logic             irq_hrd_o,
  output logic [AW-1:0]    vec_hwr_o,
  output logic [AW-1:0]    vec_hrd_o
);
  localparam int unsigned Half = DW / 2;

  hmb_sel_e         sel;
  logic [N_REG-1:0] data_hit, core_rd_clr, core_wr_clr;
  logic [N_REG-1:0] wr_pend, rd_pend, mask_wr, mask_rd;
  logic [DW-1:0]    data_rdata, status_w, mask_w;
  logic             mask_we;

  hmb_decode #(
    .N_REG(N_REG), .AW(AW), .DATA_BASE(DATA_BASE),
    .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) i_decode (
    .addr_i    (core_addr_i),
    .sel_o     (sel),
    .data_hit_o(data_hit)
  );

  assign core_rd_clr = data_hit & {N_REG{core_rd_i}};
  assign core_wr_clr = data_hit & {N_REG{core_wr_i}};
  assign mask_we     = core_wr_i && (sel == SEL_MASK);

  hmb_regfile #(.N_REG(N_REG), .DW(DW)) i_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (host_wr_i),
    .host_wdata_i(host_wdata_i),
    .host_re_i   (host_rd_i),
    .host_rdata_o(host_rdata_o),
    .core_we_i   (core_wr_clr),
    .core_sel_i  (data_hit),
    .core_wdata_i(core_wdata_i),
    .core_rdata_o(data_rdata)
  );

  hmb_pending #(.N_REG(N_REG)) i_pend_wr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (host_wr_i),
    .clr_i (core_rd_clr),
    .pend_o(wr_pend)
  );

  hmb_pending #(.N_REG(N_REG)) i_pend_rd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (host_rd_i),
    .clr_i (core_wr_clr),
    .pend_o(rd_pend)
  );

  hmb_irq #(.N_REG(N_REG)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mask_we_i  (mask_we),
    .mask_wr_d_i(core_wdata_i[N_REG-1:0]),
    .mask_rd_d_i(core_wdata_i[Half+:N_REG]),
    .wr_pend_i  (wr_pend),
    .rd_pend_i  (rd_pend),
    .mask_wr_o  (mask_wr),
    .mask_rd_o  (mask_rd),
    .irq_hwr_o  (irq_hwr_o),
    .irq_hrd_o  (irq_hrd_o)
  );

  always_comb begin
    status_w = '0;
    status_w[N_REG-1:0] = wr_pend;
    status_w[Half+:N_REG] = rd_pend;
    mask_w = '0;
    mask_w[N_REG-1:0] = mask_wr;
    mask_w[Half+:N_REG] = mask_rd;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: core_rdata_o = data_rdata;
      SEL_STAT: core_rdata_o = status_w;
      SEL_MASK: core_rdata_o = mask_w;
      default:  core_rdata_o = '0;
    endcase
  end

  assign vec_hwr_o = HWR_VEC;
  assign vec_hrd_o = HRD_VEC;
endmodule

// File: rtl/hmb_ctrl_chk.sv
module hmb_ctrl_chk #(
  parameter int unsigned N_REG = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REG-1:0] host_wr_i,
  input logic [N_REG-1:0] host_rd_i,
  input logic [N_REG-1:0] rd_clr,
  input logic [N_REG-1:0] wr_clr,
  input logic [N_REG-1:0] wr_pend,
  input logic [N_REG-1:0] rd_pend,
  input logic [N_REG-1:0] mask_wr,
  input logic [N_REG-1:0] mask_rd,
  input logic             irq_hwr_o,
  input logic             irq_hrd_o
);
  a_r2_host_rd_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rd_pend & $past(host_rd_i)) == $past(host_rd_i)));

  a_r3_core_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((wr_pend & $past(rd_clr & ~host_wr_i)) == '0));

  a_r3_core_wr_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rd_pend & $past(wr_clr & ~host_rd_i)) == '0));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((wr_pend & $past(host_wr_i)) == $past(host_wr_i)));

  a_r6_hwr_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_hwr_o == $past(|(wr_pend & mask_wr))));

  a_r6_hrd_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_hrd_o == $past(|(rd_pend & mask_rd))));

  a_r7_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i == '0 && host_rd_i == '0 && rd_clr == '0 && wr_clr == '0)
    |=> ($stable(wr_pend) && $stable(rd_pend)));
endmodule

bind hmb_ctrl hmb_ctrl_chk #(.N_REG(N_REG)) i_hmb_ctrl_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .host_wr_i(host_wr_i),
  .host_rd_i(host_rd_i),
  .rd_clr   (core_rd_clr),
  .wr_clr   (core_wr_clr),
  .wr_pend  (wr_pend),
  .rd_pend  (rd_pend),
  .mask_wr  (mask_wr),
  .mask_rd  (mask_rd),
  .irq_hwr_o(irq_hwr_o),
  .irq_hrd_o(irq_hrd_o)
);

// File: tb/test_hmb_ctrl.sv
module test_hmb_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [13:0] STAT = 14'h3FE6;
  localparam logic [13:0] MASK = 14'h3FE8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  host_wr_i = '0, host_rd_i = '0;
  logic [15:0] host_wdata_i = '0, host_rdata_o;
  logic [13:0] core_addr_i = '0;
  logic        core_wr_i = 1'b0, core_rd_i = 1'b0;
  logic [15:0] core_wdata_i = '0, core_rdata_o;
  logic        irq_hwr_o, irq_hrd_o;
  logic [13:0] vec_hwr_o, vec_hrd_o;

  int n_chk = 0, n_fail = 0;
  bit reported = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hmb_ctrl i_hmb_ctrl (.*);

  function automatic logic [13:0] dat(int n);
    return 14'h3FE0 + 14'(n);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle_inputs();
    host_wr_i = '0; host_rd_i = '0; core_wr_i = 0; core_rd_i = 0;
    core_addr_i = '0;
  endtask

  // one cycle with optional host strobes and a core access at once
  task automatic cycle(logic [5:0] hw, logic [5:0] hr, logic [15:0] hd,
                       logic [13:0] ca, logic cw, logic cr, logic [15:0] cd,
                       output logic [15:0] hq, output logic [15:0] cq);
    host_wr_i = hw; host_rd_i = hr; host_wdata_i = hd;
    core_addr_i = ca; core_wr_i = cw; core_rd_i = cr; core_wdata_i = cd;
    #1;
    hq = host_rdata_o; cq = core_rdata_o;
    tick();
    idle_inputs();
  endtask

  task automatic core_wr(logic [13:0] a, logic [15:0] d);
    logic [15:0] hq, cq;
    cycle('0, '0, '0, a, 1, 0, d, hq, cq);
  endtask

  task automatic core_rd(logic [13:0] a, output logic [15:0] d);
    logic [15:0] hq;
    cycle('0, '0, '0, a, 0, 1, '0, hq, d);
  endtask

  task automatic host_wr(int n, logic [15:0] d);
    logic [15:0] hq, cq;
    cycle(6'(1 << n), '0, d, '0, 0, 0, '0, hq, cq);
  endtask

  task automatic host_rd(int n, output logic [15:0] d);
    logic [15:0] cq;
    cycle('0, 6'(1 << n), '0, '0, 0, 0, '0, d, cq);
  endtask

  task automatic status(string tag, logic [15:0] exp);
    core_addr_i = STAT; #1;
    chk(tag, core_rdata_o, exp);
    core_addr_i = '0;
  endtask

  task automatic t_reset();
    status("R1 status after reset", 16'h0000);
    core_addr_i = MASK; #1;
    chk("R1 mask after reset", core_rdata_o, 16'h0000);
    chk("R1 irqs after reset", {14'd0, irq_hwr_o, irq_hrd_o}, 16'h0);
    chk("R8 write vector", {2'b0, vec_hwr_o}, 16'h0008);
    chk("R8 read vector", {2'b0, vec_hrd_o}, 16'h000C);
    core_addr_i = '0;
  endtask

  task automatic t_data_path();
    logic [15:0] d;
    host_wr(1, 16'hA5A5);
    core_rd(dat(1), d);
    chk("R9 core sees host data", d, 16'hA5A5);
    core_wr(dat(4), 16'h1234);
    host_rd(4, d);
    chk("R9 host sees core data", d, 16'h1234);
    status("R10 read flag 4 in bit 12", 16'h1000);
    core_wr(dat(4), 16'h0);
    status("R3 core write clears read flag", 16'h0000);
  endtask

  task automatic t_host_wins();
    logic [15:0] hq, cq;
    cycle(6'b000001, '0, 16'h1111, dat(0), 1, 0, 16'h2222, hq, cq);
    core_rd(dat(0), cq);
    chk("R9 host wins write collision", cq, 16'h1111);
    status("R3 flags clean after collision", 16'h0000);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    host_wr(3, 16'h3); host_wr(5, 16'h5); host_rd(0, d);
    status("R2 R10 mixed flags", 16'h0128);
    core_rd(dat(3), d);
    status("R3 read clears only write flag 3", 16'h0120);
    core_wr(dat(5), 16'h9);
    status("R3 write leaves write flag 5", 16'h0120);
    core_rd(dat(5), d); core_wr(dat(0), 16'h0);
    status("R3 all cleared", 16'h0000);
  endtask

  task automatic t_priority();
    logic [15:0] hq, cq;
    cycle(6'b000100, '0, 16'h7, dat(2), 0, 1, '0, hq, cq);
    status("R4 host write beats core read", 16'h0004);
    cycle('0, 6'b000100, '0, dat(2), 1, 0, 16'h8, hq, cq);
    status("R4 host read beats core write", 16'h0404);
    core_rd(dat(2), cq); core_wr(dat(2), 16'h0);
    status("R4 cleanup", 16'h0000);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    core_wr(MASK, 16'hFFFF);
    core_rd(MASK, d);
    chk("R5 unused mask bits read zero", d, 16'h3F3F);
    core_wr(MASK, 16'h0000);
    core_rd(MASK, d);
    chk("R5 mask cleared", d, 16'h0000);
  endtask

  task automatic t_irq_timing();
    logic [15:0] d;
    core_wr(MASK, 16'h3F3F);
    host_wr(2, 16'h1);
    chk("R6 hwr not yet", {15'd0, irq_hwr_o}, 16'h0);
    tick();
    chk("R6 hwr one clock later", {15'd0, irq_hwr_o}, 16'h1);
    core_rd(dat(2), d);
    chk("R6 hwr holds on clear edge", {15'd0, irq_hwr_o}, 16'h1);
    tick();
    chk("R6 hwr drops", {15'd0, irq_hwr_o}, 16'h0);
    host_rd(5, d);
    chk("R6 hrd not yet", {15'd0, irq_hrd_o}, 16'h0);
    tick();
    chk("R6 hrd asserted", {15'd0, irq_hrd_o}, 16'h1);
    core_wr(dat(5), 16'h0); tick();
    chk("R6 hrd drops", {15'd0, irq_hrd_o}, 16'h0);
  endtask

  task automatic t_masked();
    logic [15:0] d;
    core_wr(MASK, 16'h0001);
    host_wr(1, 16'h2); tick();
    chk("R6 masked flag gives no irq", {15'd0, irq_hwr_o}, 16'h0);
    core_wr(MASK, 16'h0002);
    chk("R6 irq waits for mask register", {15'd0, irq_hwr_o}, 16'h0);
    tick();
    chk("R6 unmasked irq", {15'd0, irq_hwr_o}, 16'h1);
    core_rd(dat(1), d); tick();
    chk("R6 irq cleared", {15'd0, irq_hwr_o}, 16'h0);
  endtask

  task automatic t_no_sw_clear();
    logic [15:0] d;
    core_wr(MASK, 16'h3F3F);
    host_wr(0, 16'h3); tick();
    core_wr(STAT, 16'h0000);
    core_rd(STAT, d); core_rd(MASK, d); tick();
    status("R7 status write does not clear", 16'h0001);
    chk("R7 irq survives software access", {15'd0, irq_hwr_o}, 16'h1);
    core_wr(STAT, 16'hFFFF);
    status("R7 status write does not force", 16'h0001);
    core_rd(dat(0), d);
    status("R7 cleanup", 16'h0000);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    t_reset();
    t_data_path();
    t_host_wins();
    t_flags();
    t_priority();
    t_mask();
    t_irq_timing();
    t_masked();
    t_no_sw_clear();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule